// File: doc/BRIEF.md
# Trip Latch Bank with Minimum-Duration Stretch

This block drives a bank of protective trip outputs. Each channel takes a trip request and an unlatch condition, both produced by upstream logic. A shared manual target-reset input acts on every channel. State changes only on clock edges where the processing-interval strobe `tick` is high.

A channel's output is the OR of three sources. The first is the live request. The second is a minimum-duration timer that starts on the rising edge of the request and cannot be cut short. The third is a seal-in register that feeds the output back on itself. Only the channel's unlatch input or the shared manual reset can break the seal-in. The request always overrides unlatch. A combined flag reports whether any channel is tripping.

The minimum duration is an 8-bit count of ticks, driven on `min_dur` and shared by all channels. The package constant `DEFAULT_MIN_DUR` (9) is the value the system is expected to program.

Top module: `trip_latch_bank`

## Requirements
- R1: While `trip_req[i]` is high, `trip_out[i]` is high in the same cycle, whatever `unlatch[i]` and `target_reset` do.
- R2: A request that is high on a tick edge where it was low on the previous tick edge loads the timer with `min_dur`. `trip_out[i]` then stays high for `min_dur` further ticks after that request tick, and drops in the cycle after the last of them unless a seal-in holds it.
- R3: Once loaded, the timer counts down one per tick to zero even while `unlatch[i]` or `target_reset` is high.
- R4: The package constant `DEFAULT_MIN_DUR` equals 9. With `min_dur` driven to it, a one-tick request gives exactly 9 stretched ticks.
- R5: On a tick edge where `trip_out[i]` is high and neither `unlatch[i]` nor `target_reset` is high, the seal-in sets. `trip_out[i]` then stays high after the request and timer are gone.
- R6: A tick edge with `unlatch[i]` or `target_reset` high clears the seal-in. `trip_out[i]` is low in the next cycle if there is no request and the timer is idle.
- R7: There are five independent channels. `trip_any` is high exactly when at least one bit of `trip_out` is high.
- R8: A clock edge with `rst` high clears every seal-in, timer and stored request level. With all requests low, `trip_out` is all zero from the next cycle on.
- R9: With `min_dur` = 0 no stretching occurs, and only the request and seal-in drive the output.
- R10: On edges where `tick` is low, no timer, seal-in or stored request level changes. In particular, a request that rises and falls between ticks does not load the timer and does not seal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Processing-interval strobe; state advances only when high |
| min_dur | input | 8 | Minimum trip duration in ticks; 0 disables stretching |
| trip_req | input | 5 | Per-channel trip request |
| unlatch | input | 5 | Per-channel unlatch condition |
| target_reset | input | 1 | Shared manual reset that breaks every seal-in |
| trip_out | output | 5 | Per-channel trip output |
| trip_any | output | 1 | High when any trip output is high |

## Verification
The request reaches `trip_out` combinationally, so its effect is due in the same cycle it is driven. A timer load, a count step, a seal-in set or a seal-in clear is registered on a tick edge, so each becomes visible one cycle after the tick that caused it. The bench drives inputs on the falling edge and queues the expected output for that cycle. A monitor compares the queued value just before the next rising edge, after the combinational path has settled and before any register moves. The stretch length is checked by counting queued steps from the request tick to the first low cycle.

// File: rtl/trip_pkg.sv
package trip_pkg;

    parameter int unsigned CH_COUNT = 5;
    parameter int unsigned DUR_W    = 8;

    localparam logic [DUR_W-1:0] DEFAULT_MIN_DUR = DUR_W'(9);

    // Per-channel inputs bundled for the channel slice.
    typedef struct packed {
        logic req;
        logic unl;
        logic mreset;
    } chan_in_t;

    // Per-channel state flags brought back to the top.
    typedef struct packed {
        logic stretch_busy;
        logic sealed;
    } chan_flags_t;

    function automatic logic rose(input logic now_v, input logic prev_v);
        return now_v & ~prev_v;
    endfunction

endpackage

// File: rtl/trip_min_timer.sv
module trip_min_timer #(
    parameter int unsigned DUR_W = trip_pkg::DUR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [DUR_W-1:0] load_val,
    output logic             busy
);
    logic [DUR_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (tick) begin
            if (load) begin
                remain_q <= load_val;
            end else if (remain_q != '0) begin
                remain_q <= remain_q - DUR_W'(1);
            end
        end
    end

    assign busy = (remain_q != '0);

endmodule

// File: rtl/trip_seal_cell.sv
module trip_seal_cell (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic loop_in,
    input  logic brk,
    output logic sealed
);
    logic seal_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seal_q <= 1'b0;
        end else if (tick) begin
            seal_q <= loop_in & ~brk;
        end
    end

    assign sealed = seal_q;

endmodule

// File: rtl/trip_channel.sv
module trip_channel
    import trip_pkg::*;
#(
    parameter int unsigned DUR_W = trip_pkg::DUR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [DUR_W-1:0] min_dur,
    input  chan_in_t         cin,
    output logic             trip,
    output chan_flags_t      flags
);
    logic req_prev_q;
    logic load_stretch;
    logic stretch_busy;
    logic sealed;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_prev_q <= 1'b0;
        end else if (tick) begin
            req_prev_q <= cin.req;
        end
    end

    assign load_stretch = rose(cin.req, req_prev_q);

    trip_min_timer #(.DUR_W(DUR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (load_stretch),
        .load_val (min_dur),
        .busy     (stretch_busy)
    );

    trip_seal_cell u_seal (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .loop_in (trip),
        .brk     (cin.unl | cin.mreset),
        .sealed  (sealed)
    );

    assign trip  = cin.req | stretch_busy | sealed;
    assign flags = '{stretch_busy: stretch_busy, sealed: sealed};

endmodule

// File: rtl/trip_latch_bank.sv
module trip_latch_bank
    import trip_pkg::*;
#(
    parameter int unsigned NUM_CH = trip_pkg::CH_COUNT,
    parameter int unsigned DUR_W  = trip_pkg::DUR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [DUR_W-1:0]  min_dur,
    input  logic [NUM_CH-1:0] trip_req,
    input  logic [NUM_CH-1:0] unlatch,
    input  logic              target_reset,
    output logic [NUM_CH-1:0] trip_out,
    output logic              trip_any
);
    logic [NUM_CH-1:0] timer_busy;
    logic [NUM_CH-1:0] seal_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        chan_in_t    cin;
        chan_flags_t fl;

        assign cin = '{req: trip_req[g], unl: unlatch[g], mreset: target_reset};

        trip_channel #(.DUR_W(DUR_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .min_dur (min_dur),
            .cin     (cin),
            .trip    (trip_out[g]),
            .flags   (fl)
        );

        assign timer_busy[g] = fl.stretch_busy;
        assign seal_q[g]     = fl.sealed;
    end

    assign trip_any = |trip_out;

endmodule

// File: rtl/trip_latch_bank_chk.sv
module trip_latch_bank_chk #(
    parameter int unsigned NUM_CH = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic [NUM_CH-1:0] trip_req,
    input logic [NUM_CH-1:0] unlatch,
    input logic              target_reset,
    input logic [NUM_CH-1:0] trip_out,
    input logic              trip_any,
    input logic [NUM_CH-1:0] timer_busy,
    input logic [NUM_CH-1:0] seal_q
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_prop
        p_req_forces_trip_r1: assert property (@(posedge clk) disable iff (rst)
            trip_req[g] |-> trip_out[g]);

        p_seal_forms_r5: assert property (@(posedge clk) disable iff (rst)
            (tick && trip_out[g] && !unlatch[g] && !target_reset) |=> seal_q[g]);

        p_seal_breaks_r6: assert property (@(posedge clk) disable iff (rst)
            (tick && (unlatch[g] || target_reset)) |=> !seal_q[g]);

        p_hold_between_ticks_r10: assert property (@(posedge clk) disable iff (rst)
            !tick |=> ($stable(seal_q[g]) && $stable(timer_busy[g])));
    end

    p_any_matches_r7: assert property (@(posedge clk) disable iff (rst)
        trip_any == (trip_out != '0));

    p_reset_clears_r8: assert property (@(posedge clk)
        rst |=> (seal_q == '0 && timer_busy == '0));

endmodule

bind trip_latch_bank trip_latch_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .trip_req     (trip_req),
    .unlatch      (unlatch),
    .target_reset (target_reset),
    .trip_out     (trip_out),
    .trip_any     (trip_any),
    .timer_busy   (timer_busy),
    .seal_q       (seal_q)
);

// File: tb/trip_latch_bank_bench.sv
`timescale 1ns/1ps
module trip_latch_bank_bench;
    import trip_pkg::*;

    localparam int N = 5;

    typedef struct {
        logic [N-1:0] exp_trip;
        string        tag;
    } exp_item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick = 1'b0;
    logic [7:0]   min_dur = DEFAULT_MIN_DUR;
    logic [N-1:0] trip_req = '0;
    logic [N-1:0] unlatch = '0;
    logic         target_reset = 1'b0;
    logic [N-1:0] trip_out;
    logic         trip_any;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    exp_item_t sb_q[$];

    always #4 clk = ~clk;

    trip_latch_bank u_trip_latch_bank (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .min_dur      (min_dur),
        .trip_req     (trip_req),
        .unlatch      (unlatch),
        .target_reset (target_reset),
        .trip_out     (trip_out),
        .trip_any     (trip_any)
    );

    // Monitor: compare just before the next rising edge.
    always @(negedge clk) begin
        #3;
        if (sb_q.size() > 0) begin
            exp_item_t e;
            e = sb_q.pop_front();
            n_run++;
            if (trip_out !== e.exp_trip || trip_any !== (e.exp_trip != '0)) begin
                n_fail++;
                $display("FAIL %s: trip_out=%b any=%b expected trip_out=%b any=%b",
                         e.tag, trip_out, trip_any, e.exp_trip, (e.exp_trip != '0));
            end
        end
    end

    task automatic step(input logic [N-1:0] rq, input logic [N-1:0] ul,
                        input logic mr, input logic tk, input logic rs,
                        input logic [N-1:0] ex, input string tag);
        exp_item_t e;
        @(negedge clk);
        trip_req     = rq;
        unlatch      = ul;
        target_reset = mr;
        tick         = tk;
        rst          = rs;
        e.exp_trip   = ex;
        e.tag        = tag;
        sb_q.push_back(e);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        // R8: outputs clear after reset
        step(5'b0, 5'b0, 1'b0, 1'b1, 1'b1, 5'b0, "R8 reset state");
        if (DEFAULT_MIN_DUR != 8'd9) begin
            n_run++; n_fail++;
            $display("FAIL R4: default=%0d expected 9", DEFAULT_MIN_DUR);
        end else n_run++;

        // R2/R3/R4: one-tick request under unlatch, stretched 9 ticks
        step(5'b1, 5'b1, 1'b0, 1'b1, 1'b0, 5'b1, "R1 request with unlatch");
        for (int k = 0; k < 9; k++) step(5'b0, 5'b1, 1'b0, 1'b1, 1'b0, 5'b1, "R3 R4 stretch");
        step(5'b0, 5'b1, 1'b0, 1'b1, 1'b0, 5'b0, "R2 stretch ends");

        // R5/R6: seal-in then manual reset
        step(5'b1, 5'b0, 1'b0, 1'b1, 1'b0, 5'b1, "R1 request");
        for (int k = 0; k < 9; k++) step(5'b0, 5'b0, 1'b0, 1'b1, 1'b0, 5'b1, "R2 stretch");
        for (int k = 0; k < 3; k++) step(5'b0, 5'b0, 1'b0, 1'b1, 1'b0, 5'b1, "R5 sealed");
        step(5'b0, 5'b0, 1'b1, 1'b1, 1'b0, 5'b1, "R6 reset tick");
        step(5'b0, 5'b0, 1'b0, 1'b1, 1'b0, 5'b0, "R6 manual reset clears");

        // R1/R3: request with manual reset held, timer survives it
        step(5'b1, 5'b0, 1'b1, 1'b1, 1'b0, 5'b1, "R1 request over manual reset");
        for (int k = 0; k < 9; k++) step(5'b0, 5'b0, 1'b1, 1'b1, 1'b0, 5'b1, "R3 under manual reset");
        step(5'b0, 5'b0, 1'b1, 1'b1, 1'b0, 5'b0, "R6 no seal under reset");

        // R1: request held across unlatch
        for (int k = 0; k < 4; k++) step(5'b1, 5'b0, 1'b0, 1'b1, 1'b0, 5'b1, "R1 held");
        for (int k = 0; k < 8; k++) step(5'b1, 5'b1, 1'b0, 1'b1, 1'b0, 5'b1, "R1 held over unlatch");
        step(5'b0, 5'b1, 1'b0, 1'b1, 1'b0, 5'b0, "R6 drop after request");

        // R5: unlatch pulse during timer, seal re-forms
        step(5'b1, 5'b0, 1'b0, 1'b1, 1'b0, 5'b1, "R1 request");
        for (int k = 0; k < 2; k++) step(5'b0, 5'b1, 1'b0, 1'b1, 1'b0, 5'b1, "R3 unlatch pulse");
        for (int k = 0; k < 7; k++) step(5'b0, 5'b0, 1'b0, 1'b1, 1'b0, 5'b1, "R3 stretch");
        for (int k = 0; k < 2; k++) step(5'b0, 5'b0, 1'b0, 1'b1, 1'b0, 5'b1, "R5 reseal");
        step(5'b0, 5'b1, 1'b0, 1'b1, 1'b0, 5'b1, "R6 unlatch tick");
        step(5'b0, 5'b0, 1'b0, 1'b1, 1'b0, 5'b0, "R6 unlatch clears");

        // R9: zero duration
        @(negedge clk); min_dur = 8'd0;
        step(5'b1, 5'b1, 1'b0, 1'b1, 1'b0, 5'b1, "R9 request");
        step(5'b0, 5'b1, 1'b0, 1'b1, 1'b0, 5'b0, "R9 no stretch");
        step(5'b1, 5'b0, 1'b0, 1'b1, 1'b0, 5'b1, "R9 request");
        step(5'b0, 5'b0, 1'b0, 1'b1, 1'b0, 5'b1, "R9 seal only");
        step(5'b0, 5'b1, 1'b0, 1'b1, 1'b0, 5'b1, "R6 unlatch tick");
        step(5'b0, 5'b0, 1'b0, 1'b1, 1'b0, 5'b0, "R9 cleared");

        // R10: tick gating
        @(negedge clk); min_dur = DEFAULT_MIN_DUR;
        step(5'b1, 5'b1, 1'b0, 1'b1, 1'b0, 5'b1, "R1 request");
        for (int k = 0; k < 5; k++) step(5'b0, 5'b1, 1'b0, 1'b0, 1'b0, 5'b1, "R10 frozen");
        for (int k = 0; k < 9; k++) step(5'b0, 5'b1, 1'b0, 1'b1, 1'b0, 5'b1, "R10 resumes");
        step(5'b0, 5'b1, 1'b0, 1'b1, 1'b0, 5'b0, "R10 expires");
        step(5'b1, 5'b0, 1'b0, 1'b0, 1'b0, 5'b1, "R1 request between ticks");
        step(5'b0, 5'b0, 1'b0, 1'b0, 1'b0, 5'b0, "R10 not sampled");
        step(5'b0, 5'b0, 1'b0, 1'b1, 1'b0, 5'b0, "R10 no seal");

        // R7: channels and combined flag
        @(negedge clk); min_dur = 8'd0;
        step(5'b10000, 5'b10000, 1'b0, 1'b1, 1'b0, 5'b10000, "R7 channel 4");
        step(5'b00000, 5'b10000, 1'b0, 1'b1, 1'b0, 5'b00000, "R7 any low");
        step(5'b01010, 5'b00000, 1'b0, 1'b1, 1'b0, 5'b01010, "R7 two channels");
        step(5'b00000, 5'b00000, 1'b0, 1'b1, 1'b0, 5'b01010, "R7 both sealed");
        step(5'b00000, 5'b00010, 1'b0, 1'b1, 1'b0, 5'b01010, "R7 unlatch ch1");
        step(5'b00000, 5'b00000, 1'b0, 1'b1, 1'b0, 5'b01000, "R7 independent");
        step(5'b00000, 5'b00000, 1'b1, 1'b1, 1'b0, 5'b01000, "R6 shared reset tick");
        step(5'b00000, 5'b00000, 1'b0, 1'b1, 1'b0, 5'b00000, "R6 shared reset clears");

        // R8: reset mid-stretch and sealed
        @(negedge clk); min_dur = DEFAULT_MIN_DUR;
        step(5'b00100, 5'b0, 1'b0, 1'b1, 1'b0, 5'b00100, "R1 request");
        step(5'b00000, 5'b0, 1'b0, 1'b1, 1'b0, 5'b00100, "R2 stretch");
        step(5'b00000, 5'b0, 1'b0, 1'b1, 1'b1, 5'b00100, "R8 reset cycle");
        step(5'b00000, 5'b0, 1'b0, 1'b1, 1'b0, 5'b00000, "R8 cleared");
        step(5'b00000, 5'b0, 1'b0, 1'b1, 1'b0, 5'b00000, "R8 stays clear");

        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #1600000;
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule